// File: doc/BRIEF.md
# Standby and Clock Gating Controller

This block sets the low-power state of a small microcontroller. It contains a free-running prescaler and a basic interval timer, and it drives three enables: one for the CPU clock, one for the oscillator, and a set of gated tick outputs for the peripherals. Software enters sleep by writing to a sleep register on a simple write-only register bus. The instruction decoder enters stop by pulsing a strobe. In sleep the oscillator keeps running and the interval timer keeps counting, so an overflow of the timer can end the sleep. In stop the oscillator is switched off, every derived tick freezes, and all state is held. An external interrupt ends stop. The CPU clock then comes back only after a fixed stabilisation count.

The clock-control register holds three fields. Bits [2:0] select the timer input tap. Bit 7 enables the peripheral ticks during sleep. Bits [6:3] are stored and have no function here. A write-only sleep register holds the sleep flag in bit 0. The core sees that flag on `slp_flag`, and it falls back to 0 when sleep ends.

Top module: `stby_ctrl`

## Requirements
- R1: After reset, `cpu_clk_en`=1, `osc_en`=1, `slp_flag`=0 and `wake_pulse`=0. The clock-control register reads 8'h37, which means peripheral enable (bit 7) = 0 and timer select (bits [2:0]) = 7, the top tap.
- R2: A write to address `SLP_ADDR` (default 8'h30) with data bit 0 = 1, made in run mode, enters sleep on that clock edge. From then on `cpu_clk_en`=0, `osc_en`=1 and `slp_flag`=1.
- R3: Whenever the oscillator runs, the prescaler advances once per clock. Tap k (k = 1..NTAP, on `ptap_tick[k-1]`) is high for one cycle whenever the low k prescaler bits are all ones, so it fires once every 2^k cycles.
- R4: In sleep with clock-control bit 7 = 0, taps 1..NTAP-1 are held at 0. With bit 7 = 1 they keep running during sleep.
- R5: The top tap (NTAP) is never gated. It runs in sleep whatever bit 7 holds.
- R6: The timer counts ticks of tap NTAP-7+sel, where sel is clock-control bits [2:0]. `tmr_ovf` pulses on the tick that wraps the TMR_W-bit counter. In sleep, that overflow ends sleep on the same edge. In the next cycle `cpu_clk_en`=1 and `slp_flag`=0, and `wake_pulse` is high for exactly one cycle.
- R7: In sleep with sel other than 7, the timer receives no ticks and never ends the sleep.
- R8: A `stop_req` pulse in run mode brings the next cycle `osc_en`=0 and `cpu_clk_en`=0, with all taps at 0 and `tmr_ovf` at 0. The prescaler and the timer freeze.
- R9: `ext_irq` in stop raises `osc_en` on the next edge. `cpu_clk_en` stays 0 for STAB_CNT cycles (default 256). It then rises, and `wake_pulse` is high for one cycle.
- R10: Writes to any address other than `SLP_ADDR` and `CLK_ADDR` (default 8'h31) change nothing. In stop, register writes are ignored and all state is kept.
- R11: `ext_irq` has no effect in run or sleep. `stop_req` has no effect outside run mode. If `stop_req` and a sleep write arrive in the same cycle, stop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raw oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| stop_req | input | 1 | Stop strobe from the instruction decoder |
| ext_irq | input | 1 | External interrupt; wakes from stop |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator run enable |
| ptap_tick | output | NTAP | Gated prescaler tap ticks, bit k-1 carries tap k |
| tmr_ovf | output | 1 | Interval timer overflow pulse |
| slp_flag | output | 1 | Sleep register bit 0 |
| wake_pulse | output | 1 | One-cycle wake indication to the core |

## Verification
The hardest state to reach from the ports is a timer overflow during sleep. It needs the top tap selected, and it needs up to 2^TMR_W times 2^NTAP cycles of idle clocking. The bench therefore narrows the timer to 4 bits and waits until the sleep ends, first with the peripheral enable cleared and then with it set. It then enters sleep with a low tap selected and rewrites the select field while still asleep, which shows both that the sleep cannot end and how it is rescued. Random register traffic follows, together with stop strobes and interrupts, and every cycle is compared with a model built from the requirements.

// File: rtl/stby_pkg.sv
package stby_pkg;

   typedef enum logic [1:0] {
      MODE_RUN   = 2'd0,
      MODE_SLEEP = 2'd1,
      MODE_STOP  = 2'd2,
      MODE_STAB  = 2'd3
   } stby_mode_e;

endpackage

// File: rtl/stby_prescaler.sv
// Free-running prescaler with one tick output per tap.
module stby_prescaler #(
   parameter int NTAP = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   output logic [NTAP-1:0] raw_tick
);

   logic [NTAP-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (run)
         cnt <= cnt + 1'b1;
   end

   for (genvar k = 1; k <= NTAP; k++) begin : g_tap
      assign raw_tick[k-1] = run & (&cnt[k-1:0]);
      if (k >= 2) begin : g_nest
         AST_TAP_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
            raw_tick[k-1] |-> raw_tick[k-2]); // R3
      end
   end

endmodule

// File: rtl/stby_tap_gate.sv
// Gating of peripheral taps in sleep and selection of the timer input.
module stby_tap_gate #(
   parameter int NTAP  = 10,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NTAP-1:0]  raw_tick,
   input  logic             sleeping,
   input  logic             pen,
   input  logic [SEL_W-1:0] sel,
   output logic [NTAP-1:0]  ptap_tick,
   output logic             tmr_tick
);

   localparam int IDX_W    = $clog2(NTAP);
   localparam int SEL_BASE = NTAP - (1 << SEL_W);

   logic             hold_off;
   logic             top_sel;
   logic [IDX_W-1:0] sel_idx;

   assign hold_off = sleeping & ~pen;
   assign top_sel  = &sel;

   for (genvar k = 0; k < NTAP; k++) begin : g_gate
      if (k == NTAP - 1) begin : g_free
         assign ptap_tick[k] = raw_tick[k];
      end else begin : g_gated
         assign ptap_tick[k] = raw_tick[k] & ~hold_off;
      end
   end

   always_comb begin
      sel_idx  = IDX_W'(SEL_BASE) + IDX_W'(sel);
      tmr_tick = raw_tick[sel_idx] & (top_sel | ~sleeping);
   end

   AST_SLEEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (sleeping && !pen) |-> (ptap_tick[NTAP-2:0] == '0)); // R4
   AST_TOP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (sleeping && raw_tick[NTAP-1]) |-> ptap_tick[NTAP-1]); // R5
   AST_TMR_STARVED: assert property (@(posedge clk) disable iff (!rst_n)
      (sleeping && !top_sel) |-> !tmr_tick); // R7

endmodule

// File: rtl/stby_interval_timer.sv
// Basic interval timer: counts input ticks and flags the wrap.
module stby_interval_timer #(
   parameter int TMR_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic ovf
);

   logic [TMR_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (tick)
         cnt <= cnt + 1'b1;
   end

   assign ovf = tick & (&cnt);

   AST_OVF_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (cnt == '0)); // R6
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt)); // R8

endmodule

// File: rtl/stby_mode_fsm.sv
// Run / sleep / stop / stabilisation sequencing.
module stby_mode_fsm import stby_pkg::*; #(
   parameter int STAB_CNT = 256
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       slp_req,
   input  logic       stop_req,
   input  logic       tmr_ovf,
   input  logic       ext_irq,
   output stby_mode_e mode,
   output logic       wake_pulse
);

   localparam int STW = (STAB_CNT > 2) ? $clog2(STAB_CNT) : 1;
   localparam logic [STW-1:0] STAB_LAST = STW'(STAB_CNT - 1);

   logic [STW-1:0] stab_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode       <= MODE_RUN;
         stab_cnt   <= '0;
         wake_pulse <= 1'b0;
      end else begin
         wake_pulse <= 1'b0;
         unique case (mode)
            MODE_RUN: begin
               if (stop_req)
                  mode <= MODE_STOP;
               else if (slp_req)
                  mode <= MODE_SLEEP;
            end
            MODE_SLEEP: begin
               if (tmr_ovf) begin
                  mode       <= MODE_RUN;
                  wake_pulse <= 1'b1;
               end
            end
            MODE_STOP: begin
               if (ext_irq) begin
                  mode     <= MODE_STAB;
                  stab_cnt <= '0;
               end
            end
            MODE_STAB: begin
               if (stab_cnt == STAB_LAST) begin
                  mode       <= MODE_RUN;
                  wake_pulse <= 1'b1;
               end else begin
                  stab_cnt <= stab_cnt + 1'b1;
               end
            end
            default: mode <= MODE_RUN;
         endcase
      end
   end

   AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse); // R6
   AST_STOP_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_STOP && !ext_irq) |=> (mode == MODE_STOP)); // R9
   AST_STAB_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_STAB) |=> (mode == MODE_STAB || mode == MODE_RUN)); // R9
   AST_SLEEP_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_SLEEP && !tmr_ovf) |=> (mode == MODE_SLEEP)); // R11
   AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_RUN && stop_req) |=> (mode == MODE_STOP)); // R11

endmodule

// File: rtl/stby_ctrl.sv
// Standby and clock gating controller, top level.
module stby_ctrl import stby_pkg::*; #(
   parameter int              NTAP     = 10,
   parameter int              TMR_W    = 8,
   parameter int              STAB_CNT = 256,
   parameter int              ADDR_W   = 8,
   parameter int              SEL_W    = 3,
   parameter int              PEN_BIT  = 7,
   parameter logic [ADDR_W-1:0] SLP_ADDR = ADDR_W'(8'h30),
   parameter logic [ADDR_W-1:0] CLK_ADDR = ADDR_W'(8'h31),
   parameter logic [7:0]      CKR_RST  = 8'h37
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              stop_req,
   input  logic              ext_irq,
   output logic              cpu_clk_en,
   output logic              osc_en,
   output logic [NTAP-1:0]   ptap_tick,
   output logic              tmr_ovf,
   output logic              slp_flag,
   output logic              wake_pulse
);

   if (NTAP < (1 << SEL_W)) begin : g_bad_ntap
      $error("NTAP must cover every timer select value");
   end
   if (TMR_W < 2) begin : g_bad_tmr
      $error("TMR_W must be at least 2");
   end
   if (STAB_CNT < 2) begin : g_bad_stab
      $error("STAB_CNT must be at least 2");
   end
   if (PEN_BIT < SEL_W || PEN_BIT > 7) begin : g_bad_pen
      $error("PEN_BIT must lie above the select field inside the byte");
   end
   if (SLP_ADDR == CLK_ADDR) begin : g_bad_addr
      $error("register addresses must differ");
   end

   stby_mode_e      mode;
   logic [7:0]      ckr;
   logic            slp_req;
   logic            sleeping;
   logic            tmr_tick;
   logic [NTAP-1:0] raw_tick;

   assign slp_req  = wr_en && (wr_addr == SLP_ADDR) && wr_data[0];
   assign sleeping = (mode == MODE_SLEEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ckr <= CKR_RST;
      else if (wr_en && (wr_addr == CLK_ADDR) && (mode != MODE_STOP))
         ckr <= wr_data;
   end

   stby_mode_fsm #(.STAB_CNT(STAB_CNT)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .slp_req    (slp_req),
      .stop_req   (stop_req),
      .tmr_ovf    (tmr_ovf),
      .ext_irq    (ext_irq),
      .mode       (mode),
      .wake_pulse (wake_pulse)
   );

   assign osc_en     = (mode != MODE_STOP);
   assign cpu_clk_en = (mode == MODE_RUN);
   assign slp_flag   = sleeping;

   stby_prescaler #(.NTAP(NTAP)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (osc_en),
      .raw_tick (raw_tick)
   );

   stby_tap_gate #(.NTAP(NTAP), .SEL_W(SEL_W)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_tick  (raw_tick),
      .sleeping  (sleeping),
      .pen       (ckr[PEN_BIT]),
      .sel       (ckr[SEL_W-1:0]),
      .ptap_tick (ptap_tick),
      .tmr_tick  (tmr_tick)
   );

   stby_interval_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tmr_tick),
      .ovf   (tmr_ovf)
   );

   AST_SLEEP_OSC_ON: assert property (@(posedge clk) disable iff (!rst_n)
      slp_flag |-> (osc_en && !cpu_clk_en)); // R2
   AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_clk_en && !stop_req && slp_req) |=> slp_flag); // R2
   AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |-> (ptap_tick == '0 && !tmr_ovf && !cpu_clk_en)); // R8
   AST_STOP_KEEPS_REG: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |=> $stable(ckr)); // R10
   AST_FOREIGN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != SLP_ADDR && wr_addr != CLK_ADDR) |=> $stable(ckr)); // R10
   AST_OVF_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (slp_flag && tmr_ovf) |=> (cpu_clk_en && wake_pulse)); // R6

endmodule

// File: tb/tb_stby_ctrl.sv
module tb_stby_ctrl;

   localparam int NTAP  = 10;
   localparam int TMR_W = 4;
   localparam int STAB  = 256;
   localparam logic [7:0] SLP = 8'h30;
   localparam logic [7:0] CKA = 8'h31;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic stop_req = 1'b0;
   logic ext_irq = 1'b0;
   logic cpu_clk_en, osc_en, tmr_ovf, slp_flag, wake_pulse;
   logic [NTAP-1:0] ptap_tick;

   always #10 clk = ~clk;

   stby_ctrl #(.NTAP(NTAP), .TMR_W(TMR_W), .STAB_CNT(STAB)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .stop_req(stop_req), .ext_irq(ext_irq),
      .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .ptap_tick(ptap_tick),
      .tmr_ovf(tmr_ovf), .slp_flag(slp_flag), .wake_pulse(wake_pulse));

   int checks = 0;
   int errors = 0;
   string req = "R1";

   // Reference state: 0 run, 1 sleep, 2 stop, 3 stabilisation
   int m_mode = 0;
   logic [NTAP-1:0] m_pre = '0;
   logic [TMR_W-1:0] m_cnt = '0;
   logic [7:0] m_ckr = 8'h37;
   int m_stab = 0;
   logic m_wake = 1'b0;

   function automatic logic f_raw(int tap);
      logic [NTAP-1:0] msk = NTAP'((1 << tap) - 1);
      return (m_mode != 2) && ((m_pre & msk) == msk);
   endfunction

   function automatic logic [NTAP-1:0] f_taps();
      logic [NTAP-1:0] t = '0;
      for (int k = 1; k <= NTAP; k++) begin
         t[k-1] = f_raw(k);
         if (k < NTAP && m_mode == 1 && !m_ckr[7]) t[k-1] = 1'b0;
      end
      return t;
   endfunction

   function automatic logic f_ttick();
      int tap = NTAP - 7 + int'(m_ckr[2:0]);
      if (tap != NTAP && m_mode == 1) return 1'b0;
      return f_raw(tap);
   endfunction

   function automatic logic f_ovf();
      return f_ttick() && (m_cnt == '1);
   endfunction

   task automatic compare();
      logic e_cpu = (m_mode == 0);
      logic e_osc = (m_mode != 2);
      logic e_slp = (m_mode == 1);
      logic [NTAP-1:0] e_taps = f_taps();
      logic e_ovf = f_ovf();
      checks++;
      if (cpu_clk_en !== e_cpu || osc_en !== e_osc || slp_flag !== e_slp ||
          wake_pulse !== m_wake || ptap_tick !== e_taps || tmr_ovf !== e_ovf) begin
         errors++;
         $display("FAIL %s: cpu=%b osc=%b slp=%b wake=%b taps=%h ovf=%b expected cpu=%b osc=%b slp=%b wake=%b taps=%h ovf=%b",
                  req, cpu_clk_en, osc_en, slp_flag, wake_pulse, ptap_tick, tmr_ovf,
                  e_cpu, e_osc, e_slp, m_wake, e_taps, e_ovf);
      end
   endtask

   task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                       input logic sr, input logic ei);
      logic t, o;
      int nm;
      wr_en = we; wr_addr = a; wr_data = d; stop_req = sr; ext_irq = ei;
      t = f_ttick();
      o = f_ovf();
      nm = m_mode;
      m_wake = 1'b0;
      case (m_mode)
         0: if (sr) nm = 2; else if (we && a == SLP && d[0]) nm = 1;
         1: if (o) begin nm = 0; m_wake = 1'b1; end
         2: if (ei) begin nm = 3; m_stab = 0; end
         default: if (m_stab == STAB - 1) begin nm = 0; m_wake = 1'b1; end
                  else m_stab++;
      endcase
      if (we && a == CKA && m_mode != 2) m_ckr = d;
      if (m_mode != 2) m_pre = m_pre + 1'b1;
      if (t) m_cnt = m_cnt + 1'b1;
      m_mode = nm;
      @(negedge clk);
      compare();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
   endtask

   task automatic wait_awake(input int limit);
      int n = 0;
      while (m_mode != 0 && n < limit) begin
         step(1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
         n++;
      end
      checks++;
      if (m_mode != 0) begin
         errors++;
         $display("FAIL %s: still asleep after %0d cycles, expected wake", req, limit);
      end
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not end, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      req = "R1";
      compare();
      idle(4);
      req = "R3";
      idle(2100);
      req = "R10";
      for (int i = 0; i < 60; i++) begin
         logic [7:0] a = 8'($urandom);
         if (a == SLP || a == CKA) a = 8'h55;
         step(1'b1, a, 8'hFF, 1'b0, 1'b0);
      end
      req = "R11";
      for (int i = 0; i < 20; i++) step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1);
      // sleep, peripheral ticks off, top tap timer
      req = "R2";
      step(1'b1, CKA, 8'h07, 1'b0, 1'b0);
      step(1'b1, SLP, 8'h01, 1'b0, 1'b0);
      idle(5);
      req = "R4 R5 R6";
      wait_awake(20000);
      idle(3);
      // sleep with peripheral ticks kept on
      req = "R4 R5 R6";
      step(1'b1, CKA, 8'h87, 1'b0, 1'b0);
      step(1'b1, SLP, 8'h81, 1'b0, 1'b0);
      wait_awake(20000);
      // low tap selected: timer starves in sleep
      req = "R7";
      step(1'b1, CKA, 8'h00, 1'b0, 1'b0);
      step(1'b1, SLP, 8'h01, 1'b0, 1'b0);
      idle(3000);
      req = "R11";
      step(1'b0, 8'h00, 8'h00, 1'b1, 1'b1);
      idle(10);
      req = "R6";
      step(1'b1, CKA, 8'h07, 1'b0, 1'b0);
      wait_awake(20000);
      // stop and stabilisation
      req = "R8";
      step(1'b1, CKA, 8'h87, 1'b0, 1'b0);
      step(1'b1, SLP, 8'h01, 1'b1, 1'b0);
      idle(300);
      req = "R10";
      step(1'b1, CKA, 8'h00, 1'b0, 1'b0);
      step(1'b1, SLP, 8'h01, 1'b0, 1'b0);
      idle(50);
      req = "R9";
      step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1);
      idle(STAB + 10);
      req = "R4 R10";
      step(1'b1, SLP, 8'h01, 1'b0, 1'b0);
      idle(40);
      step(1'b1, CKA, 8'h07, 1'b0, 1'b0);
      wait_awake(20000);
      // constrained random traffic
      req = "random";
      for (int i = 0; i < 60000; i++) begin
         logic we = ($urandom % 8) == 0;
         int   r  = int'($urandom % 4);
         logic [7:0] a = (r == 0) ? SLP : (r == 1) ? CKA : 8'($urandom);
         logic [7:0] d = 8'($urandom);
         logic sr = ($urandom % 300) == 0;
         logic ei = ($urandom % 40) == 0;
         step(we, a, d, sr, ei);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule